// File: doc/BRIEF.md
# Serial Read Timing Calibration Sequencer

This engine finds the fastest reliable clock divider and input-sampling delay for a serial flash read path. After `start`, it reads a reference block from the flash reader at the slowest safe divider, with every delay nibble at zero, and keeps that block in a local store. It then counts the words that are neither all zeros nor all ones. If there are too few, the block is a poor test pattern, and the engine keeps the slow setting.

With a usable reference, the engine walks the candidate dividers from the largest to the smallest. It skips every divider below the caller's minimum, which stands for the frequency ceiling. For each candidate it steps through the delay indices. An index passes only when several full-block reads in a row all match the reference. Once three neighbouring indices pass, the engine keeps the middle one, so the chosen point has margin on both sides. It writes that delay code into the divider's nibble of an accumulated timing word and moves on to the next divider.

When the engine finishes, it publishes the smallest successful divider and the timing word, or the slow divider with an all-zero timing word. A read error from the flash reader stops calibration at once and forces the slow defaults.

Top module: `rd_tune_seq`

## Requirements
- R1: During and after reset, `cfg_div` equals SLOW_DIV (16), `cfg_timing` is zero, and `done` and `rd_start` are low.
- R2: The first burst after `start` is the reference read. It uses `rd_div` = SLOW_DIV and `rd_timing` = 0.
- R3: When fewer than MIN_VARIED words of the reference differ from both 0x00000000 and 0xFFFFFFFF, no further burst is issued. The run then ends with `cfg_div` = SLOW_DIV, `cfg_timing` = 0 and `fail` = 0. Reaching exactly MIN_VARIED such words is enough to start calibrating.
- R4: Candidate dividers are tried in descending order from MAX_DIV. A divider below `min_div` (0 counts as 1) is never requested.
- R5: Delay index i is driven as the 4-bit code {i even, i/2[2:0]}, that is (i/2) | 8 when i is even. The code sits in `rd_timing` bits [(d-1)*4+3 : (d-1)*4] for divider d. Indices for one divider are tried in increasing order starting at 0.
- R6: An index passes only after NUM_READS consecutive full-block reads all match the reference. A mismatch fails the index and moves on without further reads at that index.
- R7: A pass counter is cleared by any failing index. When three indices in a row pass, the middle one (i-1) is recorded and no further index is tried for that divider.
- R8: The final `cfg_div` is the smallest divider that found a setting, or SLOW_DIV if none did. `cfg_timing` holds the recorded nibble of every successful divider and zero in all other nibbles.
- R9: `rd_err` during any burst ends the run with `fail` = 1, `cfg_div` = SLOW_DIV and `cfg_timing` = 0.
- R10: `done` is high for exactly one cycle per run. `cfg_div`, `cfg_timing` and `fail` change only in that cycle and hold afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calibration run (taken only when idle) |
| min_div | input | CAND_W | Smallest divider allowed by the frequency ceiling |
| rd_start | output | 1 | One-cycle request for a full-block burst |
| rd_div | output | DIV_W | Divider to use for the requested burst |
| rd_timing | output | TIMING_W | Timing word to use for the requested burst |
| rd_valid | input | 1 | Burst data beat valid |
| rd_data | input | WORD_W | Burst data beat |
| rd_err | input | 1 | Burst failed at the transport level |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Last run aborted on a read error |
| cfg_div | output | DIV_W | Chosen divider |
| cfg_timing | output | TIMING_W | Chosen timing word |

## Verification
The bench targets the threshold of varied words at one below and exactly at the limit. A screen that is off by one would either calibrate on a flat pattern or refuse a usable one. One delay index is made to fail only on its tenth read; a design that stops short of NUM_READS reads would keep that index and record a different nibble. Pass runs broken after two passes check that the counter clears on a failure and that the middle of the first triple is kept, not its first or last entry. Aborts during the reference read and during a trial, issued after a successful run, show that a read error restores the slow defaults and does not keep stale results.

// File: rtl/rd_tune_pkg.sv
package rd_tune_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REF_REQ,
    ST_REF_RX,
    ST_CHECK,
    ST_DIV_SEL,
    ST_TRY_REQ,
    ST_TRY_RX,
    ST_EVAL,
    ST_FINISH
  } tune_state_e;

  // Delay step to timing code: coarse part is step/2, fine bit set on even steps.
  function automatic logic [3:0] delay_code(input logic [3:0] step);
    return {~step[0], step[3:1]};
  endfunction

endpackage

// File: rtl/rd_tune_refmem.sv
module rd_tune_refmem #(
  parameter int DEPTH = 4096,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/rd_tune_screen.sv
module rd_tune_screen #(
  parameter int WORD_W     = 32,
  parameter int MIN_VARIED = 64,
  localparam int CW = $clog2(MIN_VARIED + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  output logic              enough
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          varied;

  assign varied = (word != '0) && (word != '1);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (valid && varied && (cnt_q != CW'(MIN_VARIED)))
      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign enough = (cnt_q == CW'(MIN_VARIED));

  // R3: flat words never advance the usability count
  a_r3_flat_word_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !clr && !varied) |=> $stable(cnt_q));

endmodule

// File: rtl/rd_tune_runtrk.sv
module rd_tune_runtrk #(
  parameter int RUN_LEN = 3,
  localparam int RW = $clog2(RUN_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic eval,
  input  logic pass,
  output logic hit
);

  logic [RW-1:0] run_q, run_d;

  assign hit = eval && pass && (run_q == RW'(RUN_LEN - 1));

  always_comb begin
    run_d = run_q;
    if (clr)
      run_d = '0;
    else if (eval)
      run_d = (pass && !hit) ? run_q + RW'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

endmodule

// File: rtl/rd_tune_seq.sv
module rd_tune_seq
  import rd_tune_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int BLOCK_WORDS = 4096,
  parameter int MIN_VARIED  = 64,
  parameter int NUM_READS   = 10,
  parameter int NUM_DELAYS  = 12,
  parameter int MAX_DIV     = 5,
  parameter int SLOW_DIV    = 16,
  parameter int TIMING_W    = 32,
  parameter int RUN_LEN     = 3,
  localparam int CAND_W = $clog2(MAX_DIV + 1),
  localparam int DIV_W  = $clog2(SLOW_DIV + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CAND_W-1:0]   min_div,
  output logic                rd_start,
  output logic [DIV_W-1:0]    rd_div,
  output logic [TIMING_W-1:0] rd_timing,
  input  logic                rd_valid,
  input  logic [WORD_W-1:0]   rd_data,
  input  logic                rd_err,
  output logic                done,
  output logic                fail,
  output logic [DIV_W-1:0]    cfg_div,
  output logic [TIMING_W-1:0] cfg_timing
);

  localparam int BEAT_W = $clog2(BLOCK_WORDS);
  localparam int IDX_W  = $clog2(NUM_DELAYS);
  localparam int REP_W  = $clog2(NUM_READS);

  tune_state_e         state_q, state_d;
  logic [CAND_W-1:0]   cand_q, cand_d, best_q, best_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [REP_W-1:0]    rep_q, rep_d;
  logic [BEAT_W-1:0]   beat_q, beat_d;
  logic                mism_q, mism_d, found_q, found_d, abort_q, abort_d;
  logic [TIMING_W-1:0] acc_q, acc_d, cfg_tim_q, cfg_tim_d;
  logic [DIV_W-1:0]    cfg_div_q, cfg_div_d;
  logic                fail_q, fail_d, done_q, done_d;

  logic [WORD_W-1:0]   ref_word;
  logic                ref_we, enough, run_hit, trk_eval, last_beat, last_rep, in_ref;
  logic [CAND_W-1:0]   eff_min;
  logic [3:0]          try_code, keep_code;

  function automatic logic [TIMING_W-1:0] place(input logic [TIMING_W-1:0] base,
                                                input logic [CAND_W-1:0]   slot,
                                                input logic [3:0]          code);
    int sh;
    sh = (slot == '0) ? 0 : (int'(slot) - 1) * 4;
    return (base & ~(TIMING_W'(4'hF) << sh)) | (TIMING_W'(code) << sh);
  endfunction

  assign eff_min   = (min_div == '0) ? CAND_W'(1) : min_div;
  assign last_beat = (beat_q == BEAT_W'(BLOCK_WORDS - 1));
  assign last_rep  = (rep_q == REP_W'(NUM_READS - 1));
  assign in_ref    = (state_q == ST_REF_REQ) || (state_q == ST_REF_RX);
  assign try_code  = delay_code(4'(idx_q));
  assign keep_code = delay_code(4'(idx_q - IDX_W'(RUN_LEN / 2)));
  assign ref_we    = (state_q == ST_REF_RX) && rd_valid && !rd_err;
  assign trk_eval  = (state_q == ST_EVAL) && (mism_q || last_rep);

  rd_tune_refmem #(.DEPTH(BLOCK_WORDS), .WIDTH(WORD_W)) u_ref (
    .clk(clk), .we(ref_we), .waddr(beat_q), .wdata(rd_data),
    .raddr(beat_q), .rdata(ref_word));

  rd_tune_screen #(.WORD_W(WORD_W), .MIN_VARIED(MIN_VARIED)) u_screen (
    .clk(clk), .rst_n(rst_n), .clr(state_q == ST_REF_REQ),
    .valid(ref_we), .word(rd_data), .enough(enough));

  rd_tune_runtrk #(.RUN_LEN(RUN_LEN)) u_run (
    .clk(clk), .rst_n(rst_n), .clr(state_q == ST_DIV_SEL),
    .eval(trk_eval), .pass(!mism_q), .hit(run_hit));

  always_comb begin
    state_d   = state_q;
    cand_d    = cand_q;
    best_d    = best_q;
    idx_d     = idx_q;
    rep_d     = rep_q;
    beat_d    = beat_q;
    mism_d    = mism_q;
    found_d   = found_q;
    abort_d   = abort_q;
    acc_d     = acc_q;
    cfg_div_d = cfg_div_q;
    cfg_tim_d = cfg_tim_q;
    fail_d    = fail_q;
    done_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_REF_REQ;
        beat_d  = '0;
        found_d = 1'b0;
        abort_d = 1'b0;
        acc_d   = '0;
        cand_d  = CAND_W'(MAX_DIV);
      end
      ST_REF_REQ: state_d = ST_REF_RX;
      ST_REF_RX: begin
        if (rd_err) begin
          abort_d = 1'b1;
          state_d = ST_FINISH;
        end else if (rd_valid) begin
          beat_d = last_beat ? '0 : beat_q + BEAT_W'(1);
          if (last_beat) state_d = ST_CHECK;
        end
      end
      ST_CHECK: state_d = enough ? ST_DIV_SEL : ST_FINISH;
      ST_DIV_SEL: begin
        if (cand_q < eff_min) begin
          state_d = ST_FINISH;
        end else begin
          idx_d   = '0;
          rep_d   = '0;
          mism_d  = 1'b0;
          beat_d  = '0;
          state_d = ST_TRY_REQ;
        end
      end
      ST_TRY_REQ: state_d = ST_TRY_RX;
      ST_TRY_RX: begin
        if (rd_err) begin
          abort_d = 1'b1;
          state_d = ST_FINISH;
        end else if (rd_valid) begin
          mism_d = mism_q | (rd_data != ref_word);
          beat_d = last_beat ? '0 : beat_q + BEAT_W'(1);
          if (last_beat) state_d = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (!mism_q && !last_rep) begin
          rep_d   = rep_q + REP_W'(1);
          state_d = ST_TRY_REQ;
        end else if (run_hit) begin
          acc_d   = place(acc_q, cand_q, keep_code);
          best_d  = cand_q;
          found_d = 1'b1;
          cand_d  = cand_q - CAND_W'(1);
          state_d = ST_DIV_SEL;
        end else if (idx_q == IDX_W'(NUM_DELAYS - 1)) begin
          cand_d  = cand_q - CAND_W'(1);
          state_d = ST_DIV_SEL;
        end else begin
          idx_d   = idx_q + IDX_W'(1);
          rep_d   = '0;
          mism_d  = 1'b0;
          state_d = ST_TRY_REQ;
        end
      end
      ST_FINISH: begin
        cfg_div_d = (found_q && !abort_q) ? DIV_W'(best_q) : DIV_W'(SLOW_DIV);
        cfg_tim_d = abort_q ? '0 : acc_q;
        fail_d    = abort_q;
        done_d    = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cand_q    <= '0;
      best_q    <= '0;
      idx_q     <= '0;
      rep_q     <= '0;
      beat_q    <= '0;
      mism_q    <= 1'b0;
      found_q   <= 1'b0;
      abort_q   <= 1'b0;
      acc_q     <= '0;
      cfg_div_q <= DIV_W'(SLOW_DIV);
      cfg_tim_q <= '0;
      fail_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cand_q  <= cand_d;
      best_q  <= best_d;
      idx_q   <= idx_d;
      rep_q   <= rep_d;
      beat_q  <= beat_d;
      mism_q  <= mism_d;
      found_q <= found_d;
      abort_q <= abort_d;
      acc_q   <= acc_d;
      done_q  <= done_d;
      if (done_d) begin
        cfg_div_q <= cfg_div_d;
        cfg_tim_q <= cfg_tim_d;
        fail_q    <= fail_d;
      end
    end
  end

  assign rd_start   = (state_q == ST_REF_REQ) || (state_q == ST_TRY_REQ);
  assign rd_div     = in_ref ? DIV_W'(SLOW_DIV) : DIV_W'(cand_q);
  assign rd_timing  = in_ref ? '0 : place(acc_q, cand_q, try_code);
  assign done       = done_q;
  assign fail       = fail_q;
  assign cfg_div    = cfg_div_q;
  assign cfg_timing = cfg_tim_q;

  // R10: done lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: published results move only with done
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(cfg_div) && $stable(cfg_timing) && $stable(fail)));

  // R4: no trial burst below the divider floor or above the top candidate
  a_r4_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && rd_div != DIV_W'(SLOW_DIV)) |->
      (rd_div >= DIV_W'(eff_min) && rd_div <= DIV_W'(MAX_DIV)));

  // R9: an aborted run publishes the slow defaults
  a_r9_abort_slow: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |-> (cfg_div == DIV_W'(SLOW_DIV) && cfg_timing == '0));

  // R6: a mismatching index is never retried
  a_r6_no_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EVAL && mism_q) |=> (state_q != ST_TRY_REQ || idx_q != $past(idx_q)));

endmodule

// File: tb/tb_rd_tune_seq.sv
module tb_rd_tune_seq;
  localparam int BW = 8, NV = 4, NR = 10, ND = 12, MD = 5, SLOW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, start, rd_start, rd_valid, rd_err, done, fail;
  logic [2:0]  min_div;
  logic [4:0]  rd_div, cfg_div;
  logic [31:0] rd_timing, rd_data, cfg_timing;

  int total = 0, bad = 0;

  // reader model state
  logic [11:0] pmask [1:5];
  int          flaky [1:5];
  int          nvaried = BW;
  int          err_at = -1;
  int          bursts, norder, last_d, last_idx, rep, first_div;
  int          dbursts [32];
  int          order [8];
  logic [36:0] last_set;
  logic [31:0] ref_tim;
  bit          seq_bad;

  rd_tune_seq #(.BLOCK_WORDS(BW), .MIN_VARIED(NV)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .min_div(min_div),
    .rd_start(rd_start), .rd_div(rd_div), .rd_timing(rd_timing),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
    .done(done), .fail(fail), .cfg_div(cfg_div), .cfg_timing(cfg_timing));

  function automatic logic [31:0] word(int b);
    if (b < nvaried) return 32'h5A00_0100 + 32'(b);
    return (b % 2 == 1) ? 32'hFFFF_FFFF : 32'h0;
  endfunction

  function automatic int code_of(int i);
    return (i / 2) | ((i % 2 == 0) ? 8 : 0);
  endfunction

  function automatic int idx_of(logic [3:0] c);
    return int'(c[2:0]) * 2 + (c[3] ? 0 : 1);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reset_model();
    bursts = 0; norder = 0; last_d = 0; last_idx = 0; rep = 0;
    first_div = -1; ref_tim = '1; seq_bad = 0; last_set = '1;
    for (int k = 0; k < 32; k++) dbursts[k] = 0;
  endtask

  task automatic serve();
    int d, idx;
    bit corrupt;
    logic [31:0] t;
    d = int'(rd_div); t = rd_timing; idx = 0; corrupt = 0;
    bursts++;
    dbursts[d]++;
    if (first_div < 0) begin first_div = d; ref_tim = t; end
    if ({rd_div, t} == last_set) rep++;
    else begin
      rep = 0;
      if (d >= 1 && d <= MD) begin
        idx = idx_of(4'(t >> ((d - 1) * 4)));
        if (d != last_d) begin
          if (idx != 0) seq_bad = 1;
          order[norder] = d; norder++;
        end else if (idx != last_idx + 1) seq_bad = 1;
        last_d = d; last_idx = idx;
      end
    end
    last_set = {rd_div, t};
    if (d >= 1 && d <= MD) begin
      idx = last_idx;
      corrupt = !pmask[d][idx] || (idx == flaky[d] && rep == NR - 1);
    end
    for (int b = 0; b < BW; b++) begin
      @(negedge clk);
      if (bursts == err_at && b == 2) begin
        rd_valid = 0; rd_err = 1;
        return;
      end
      rd_valid = 1;
      rd_data = word(b) ^ ((corrupt && b == BW - 1) ? 32'h1 : 32'h0);
    end
  endtask

  initial begin
    rd_valid = 0; rd_err = 0; rd_data = 0;
    forever begin
      @(negedge clk);
      rd_valid = 0; rd_err = 0;
      if (rd_start) serve();
    end
  end

  // Runs one calibration and checks it against the requirements.
  task automatic run_cal(string tag, int mind, bit exp_abort);
    int ediv = SLOW, etried = 0;
    logic [31:0] etim = 0;
    int eb [1:5];
    bit usable = (nvaried >= NV);
    logic [4:0] hd;
    logic [31:0] ht;
    for (int d = 1; d <= MD; d++) eb[d] = 0;
    if (usable && !exp_abort)
      for (int d = MD; d >= mind; d--) begin
        int run = 0, pick = -1;
        etried++;
        for (int i = 0; i < ND && pick < 0; i++) begin
          bit p = pmask[d][i] && flaky[d] != i;
          eb[d] += p ? NR : (pmask[d][i] ? NR : 1);
          run = p ? run + 1 : 0;
          if (run == 3) pick = i - 1;
        end
        if (pick >= 0) begin
          ediv = d;
          etim |= 32'(code_of(pick)) << ((d - 1) * 4);
        end
      end
    reset_model();
    min_div = 3'(mind);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    check({tag, " R9 fail flag"}, 32'(fail), 32'(exp_abort));
    check({tag, " R8 divider"}, 32'(cfg_div), 32'(ediv));
    check({tag, " R5 timing"}, cfg_timing, etim);
    check({tag, " R2 ref divider"}, 32'(first_div), 32'(SLOW));
    check({tag, " R2 ref timing"}, ref_tim, 32'h0);
    if (!exp_abort) begin
      if (!usable) check({tag, " R3 single burst"}, 32'(bursts), 32'd1);
      check({tag, " R4 dividers tried"}, 32'(norder), 32'(etried));
      for (int k = 0; k < norder && k < etried; k++)
        check({tag, " R4 order"}, 32'(order[k]), 32'(MD - k));
      for (int d = 1; d <= MD; d++)
        check({tag, " R6 R7 bursts per divider"}, 32'(dbursts[d]), 32'(eb[d]));
      check({tag, " R5 index order"}, 32'(seq_bad), 32'd0);
    end
    hd = cfg_div; ht = cfg_timing;
    @(negedge clk);
    check({tag, " R10 done width"}, 32'(done), 32'd0);
    repeat (4) @(negedge clk);
    check({tag, " R10 hold"}, {cfg_timing[26:0], cfg_div}, {ht[26:0], hd});
  endtask

  task automatic set_masks(logic [11:0] m5, logic [11:0] m4, logic [11:0] m3,
                           logic [11:0] m2, logic [11:0] m1);
    pmask[5] = m5; pmask[4] = m4; pmask[3] = m3; pmask[2] = m2; pmask[1] = m1;
    for (int d = 1; d <= MD; d++) flaky[d] = -1;
  endtask

  task automatic t_reset();
    check("R1 reset div", 32'(cfg_div), 32'(SLOW));
    check("R1 reset timing", cfg_timing, 32'h0);
    check("R1 reset done", {31'h0, done}, 32'h0);
    check("R1 reset rd_start", {31'h0, rd_start}, 32'h0);
  endtask

  task automatic t_flat();
    set_masks('1, '1, '1, '1, '1);
    nvaried = NV - 1;
    run_cal("flat R3", 1, 0);
    nvaried = NV;
    run_cal("threshold R3", 1, 0);
    nvaried = BW;
  endtask

  task automatic t_spread();
    set_masks(12'hFE0, 12'hFFF, 12'hE00, 12'h01C, 12'h038);
    run_cal("spread R8", 1, 0);
    check("spread R5 word", cfg_timing, 32'h000B_0D1A);
  endtask

  task automatic t_abort_trial();
    err_at = 5;
    run_cal("abort trial R9", 1, 1);
    err_at = -1;
  endtask

  task automatic t_floor();
    set_masks(12'hFE0, 12'hFFF, 12'hE00, 12'h01C, 12'h038);
    run_cal("floor R4", 3, 0);
    check("floor R4 no div1", 32'(dbursts[1]), 32'd0);
    check("floor R4 no div2", 32'(dbursts[2]), 32'd0);
  endtask

  task automatic t_none();
    set_masks('0, '0, '0, '0, '0);
    run_cal("none R8", 1, 0);
  endtask

  task automatic t_flaky();
    set_masks(12'hFFF, '0, '0, '0, '0);
    flaky[5] = 1;
    run_cal("flaky R6", 1, 0);
    check("flaky R6 word", cfg_timing, 32'h0001_0000);
  endtask

  task automatic t_runs();
    set_masks('0, '0, '0, 12'hE1B, '0);
    run_cal("runs R7", 1, 0);
    check("runs R7 word", cfg_timing, 32'h0000_00D0);
  endtask

  task automatic t_abort_ref();
    err_at = 1;
    run_cal("abort ref R9", 1, 1);
    err_at = -1;
  endtask

  initial begin
    rst_n = 0; start = 0; min_div = 3'd1;
    for (int d = 1; d <= MD; d++) begin pmask[d] = '1; flaky[d] = -1; end
    reset_model();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_flat();
    t_spread();
    t_abort_trial();
    t_floor();
    t_none();
    t_flaky();
    t_runs();
    t_abort_ref();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule